// File: doc/BRIEF.md
# Paged Read Sequencer with CRC

This block produces the response bytes of an extended memory-read command for a 128-byte one-time-programmable array that is split into four 32-byte pages. A byte-level front end hands it the command byte and a two-byte start address. The consumer then asks for output bytes one at a time. For each page it sends the page's redirection byte, then a 16-bit check value over the header, then the page data from the current offset to the end of the page, and then a 16-bit check value over that data. After the last page it answers every request with all-ones.

The array sits outside the block behind a synchronous read port with one cycle of latency. The per-page redirection bytes come in as one flat vector, one byte per page, with page 0 in the lowest byte. A bus-reset input ends the transaction at any point.

Top module: `paged_read_seq`

## Requirements
- R1: A transaction starts only when the first byte after reset is 0xA5. Any other first byte leaves the block silent (no out_valid, no mem_rd_en) until rst or bus_rst.
- R2: The first byte given out is the redirection byte of page addr[6:5], where addr = {high byte, low byte}. Address bits 15..7 are ignored.
- R3: The two bytes after that first redirection byte are the bitwise inverse of a CRC-16 (polynomial x^16+x^15+x^2+1, reflected constant 0xA001, LSB of each byte first, initial value 0). The CRC is taken over 0xA5, the low address byte, the high address byte and the redirection byte, and its low byte is sent first.
- R4: Data bytes follow from the start address up to and including offset 31 of that page.
- R5: After the last data byte of a page come two bytes: the inverted CRC over only the data bytes sent from that page, low byte first.
- R6: For every page after the first, the block sends that page's redirection byte, then the inverted CRC of that byte alone, then data from offset 0.
- R7: After the page CRC of page 3, every requested byte is 0xFF.
- R8: A pulse on bus_rst (or rst) aborts at any point. out_valid is low in the next cycle and the block again waits for a command.
- R9: A redirection, CRC or 0xFF byte arrives with out_valid one cycle after the request. A data byte drives mem_rd_en in the request cycle, and out_valid rises two cycles after the request.
- R10: out_req while a data byte is pending is ignored, and in_valid during the response phase is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst | input | 1 | Bus reset: abort the transaction |
| in_valid | input | 1 | in_byte carries a command or address byte |
| in_byte | input | 8 | Incoming command/address byte |
| out_req | input | 1 | Request for the next response byte |
| out_valid | output | 1 | One-cycle pulse: out_byte holds the answer |
| out_byte | output | 8 | Response byte |
| mem_rd_en | output | 1 | Array read strobe |
| mem_rd_addr | output | 7 | Array read address |
| mem_rd_data | input | 8 | Array read data, one cycle after mem_rd_en |
| redir_bytes | input | 32 | Redirection bytes, page p in bits 8p+7..8p |

## Verification
The bench raises out_req for one cycle at a falling edge. For header, CRC and all-ones bytes it samples out_valid and out_byte at the next falling edge, one rising edge later. For data bytes it first confirms that out_valid is still low at that falling edge, then samples one falling edge later, because the array read adds a second register. After a bus reset the bench looks at out_valid at the first falling edge that follows. Every check uses these fixed offsets and never waits open-ended, so a byte that arrives early or late is reported as a latency failure.

// File: rtl/prs_pkg.sv
package prs_pkg;

  localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR_LO,
    S_ADDR_HI,
    S_REDIR,
    S_RCRC_LO,
    S_RCRC_HI,
    S_DATA,
    S_DWAIT,
    S_DCRC_LO,
    S_DCRC_HI,
    S_DONE,
    S_DEAD
  } seq_state_t;

  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/prs_crc16.sv
module prs_crc16 (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        shift,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import prs_pkg::*;

  logic [15:0] base;
  assign base = clr ? 16'h0000 : crc;

  always_ff @(posedge clk) begin
    if (rst)        crc <= 16'h0000;
    else if (shift) crc <= crc16_step(base, din);
    else if (clr)   crc <= 16'h0000;
  end
endmodule

// File: rtl/prs_redir_sel.sv
module prs_redir_sel #(
  parameter int PAGES  = 4,
  parameter int PIDX_W = 2
) (
  input  logic [PAGES*8-1:0] redir_flat,
  input  logic [PIDX_W-1:0]  page_idx,
  output logic [7:0]         redir_byte
);
  logic [7:0] table_q [PAGES];

  for (genvar p = 0; p < PAGES; p++) begin : g_unpack
    assign table_q[p] = redir_flat[p*8 +: 8];
  end

  assign redir_byte = table_q[page_idx];
endmodule

// File: rtl/prs_fsm.sv
module prs_fsm #(
  parameter int          ADDR_W   = 7,
  parameter int          PAGE_W   = 5,
  parameter logic [7:0]  CMD_CODE = 8'hA5,
  localparam int         PIDX_W   = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              out_req,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  input  logic [7:0]        redir_byte,
  output logic [PIDX_W-1:0] page_idx,
  output logic              crc_clr,
  output logic              crc_shift,
  output logic [7:0]        crc_din,
  input  logic [15:0]       crc
);
  import prs_pkg::*;

  seq_state_t        state, nxt;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        lo_q;
  logic [15:0]       full_addr;
  logic              last_in_page, last_page;
  logic              load_out, ptr_inc, ptr_load, rd_en;
  logic [7:0]        out_nxt;

  assign full_addr    = {in_byte, lo_q};
  assign page_idx     = ptr[ADDR_W-1:PAGE_W];
  assign last_in_page = &ptr[PAGE_W-1:0];
  assign last_page    = &page_idx;
  assign mem_rd_addr  = ptr;
  assign mem_rd_en    = rd_en;

  always_comb begin
    nxt       = state;
    crc_clr   = 1'b0;
    crc_shift = 1'b0;
    crc_din   = in_byte;
    rd_en     = 1'b0;
    load_out  = 1'b0;
    out_nxt   = 8'hFF;
    ptr_inc   = 1'b0;
    ptr_load  = 1'b0;
    case (state)
      S_IDLE: if (in_valid) begin
        if (in_byte == CMD_CODE) begin
          crc_clr   = 1'b1;
          crc_shift = 1'b1;
          nxt       = S_ADDR_LO;
        end else begin
          nxt = S_DEAD;
        end
      end
      S_ADDR_LO: if (in_valid) begin
        crc_shift = 1'b1;
        nxt       = S_ADDR_HI;
      end
      S_ADDR_HI: if (in_valid) begin
        crc_shift = 1'b1;
        ptr_load  = 1'b1;
        nxt       = S_REDIR;
      end
      S_REDIR: if (out_req) begin
        load_out  = 1'b1;
        out_nxt   = redir_byte;
        crc_shift = 1'b1;
        crc_din   = redir_byte;
        nxt       = S_RCRC_LO;
      end
      S_RCRC_LO: if (out_req) begin
        load_out = 1'b1;
        out_nxt  = ~crc[7:0];
        nxt      = S_RCRC_HI;
      end
      S_RCRC_HI: if (out_req) begin
        load_out = 1'b1;
        out_nxt  = ~crc[15:8];
        crc_clr  = 1'b1;
        nxt      = S_DATA;
      end
      S_DATA: if (out_req) begin
        rd_en = 1'b1;
        nxt   = S_DWAIT;
      end
      S_DWAIT: begin
        load_out  = 1'b1;
        out_nxt   = mem_rd_data;
        crc_shift = 1'b1;
        crc_din   = mem_rd_data;
        if (last_in_page) nxt = S_DCRC_LO;
        else begin
          ptr_inc = 1'b1;
          nxt     = S_DATA;
        end
      end
      S_DCRC_LO: if (out_req) begin
        load_out = 1'b1;
        out_nxt  = ~crc[7:0];
        nxt      = S_DCRC_HI;
      end
      S_DCRC_HI: if (out_req) begin
        load_out = 1'b1;
        out_nxt  = ~crc[15:8];
        crc_clr  = 1'b1;
        if (last_page) nxt = S_DONE;
        else begin
          ptr_inc = 1'b1;
          nxt     = S_REDIR;
        end
      end
      S_DONE: if (out_req) begin
        load_out = 1'b1;
        out_nxt  = 8'hFF;
      end
      S_DEAD: nxt = S_DEAD;
      default: nxt = S_IDLE;
    endcase
    if (bus_rst) rd_en = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || bus_rst) begin
      state     <= S_IDLE;
      out_valid <= 1'b0;
      out_byte  <= 8'hFF;
      ptr       <= '0;
      lo_q      <= 8'h00;
    end else begin
      state     <= nxt;
      out_valid <= load_out;
      if (load_out) out_byte <= out_nxt;
      if (state == S_ADDR_LO && in_valid) lo_q <= in_byte;
      if (ptr_load)     ptr <= full_addr[ADDR_W-1:0];
      else if (ptr_inc) ptr <= ptr + 1'b1;
    end
  end

  // Header, CRC and fill bytes answer one cycle after the request.
  assert_hdr_latency_R9: assert property (@(posedge clk) disable iff (rst || bus_rst)
    (out_req && (state inside {S_REDIR, S_RCRC_LO, S_RCRC_HI, S_DCRC_LO, S_DCRC_HI, S_DONE}))
    |=> out_valid);

  // Data bytes: nothing in the read cycle, valid in the cycle after.
  assert_data_latency_R9: assert property (@(posedge clk) disable iff (rst || bus_rst)
    mem_rd_en |=> (!out_valid ##1 out_valid));

  assert_bad_cmd_silent_R1: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEAD) |-> (!out_valid && !mem_rd_en));

  assert_done_fill_R7: assert property (@(posedge clk) disable iff (rst || bus_rst)
    (state == S_DONE && out_req) |=> (out_valid && out_byte == 8'hFF));

  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> (state == S_IDLE && !out_valid));
endmodule

// File: rtl/paged_read_seq.sv
module paged_read_seq #(
  parameter int         ADDR_W   = 7,
  parameter int         PAGE_W   = 5,
  parameter logic [7:0] CMD_CODE = 8'hA5,
  localparam int        PIDX_W   = ADDR_W - PAGE_W,
  localparam int        PAGES    = 1 << PIDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              out_req,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  input  logic [PAGES*8-1:0] redir_bytes
);
  logic [PIDX_W-1:0] page_idx;
  logic [7:0]        redir_byte;
  logic              crc_clr, crc_shift;
  logic [7:0]        crc_din;
  logic [15:0]       crc;

  prs_redir_sel #(.PAGES(PAGES), .PIDX_W(PIDX_W)) u_sel (
    .redir_flat (redir_bytes),
    .page_idx   (page_idx),
    .redir_byte (redir_byte)
  );

  prs_crc16 u_crc (
    .clk   (clk),
    .rst   (rst),
    .clr   (crc_clr),
    .shift (crc_shift),
    .din   (crc_din),
    .crc   (crc)
  );

  prs_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CMD_CODE(CMD_CODE)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .bus_rst     (bus_rst),
    .in_valid    (in_valid),
    .in_byte     (in_byte),
    .out_req     (out_req),
    .out_valid   (out_valid),
    .out_byte    (out_byte),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .redir_byte  (redir_byte),
    .page_idx    (page_idx),
    .crc_clr     (crc_clr),
    .crc_shift   (crc_shift),
    .crc_din     (crc_din),
    .crc         (crc)
  );
endmodule

// File: tb/paged_read_seq_tb.sv
`timescale 1ns/1ps
module paged_read_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_rst = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_req = 1'b0;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       mem_rd_en;
  logic [6:0] mem_rd_addr;
  logic [7:0] mem_q;
  logic [31:0] redir_bytes = 32'h3C_A7_FD_FF;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  paged_read_seq u_dut (
    .clk(clk), .rst(rst), .bus_rst(bus_rst),
    .in_valid(in_valid), .in_byte(in_byte),
    .out_req(out_req), .out_valid(out_valid), .out_byte(out_byte),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_q),
    .redir_bytes(redir_bytes)
  );

  function automatic logic [7:0] memval(input int a);
    return 8'((a * 29 + 11) ^ (a >> 2));
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_q <= memval(int'(mem_rd_addr));

  function automatic logic [7:0] redir_of(input int p);
    return redir_bytes[p*8 +: 8];
  endfunction

  function automatic logic [15:0] tb_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] v = c;
    logic [7:0]  s = b;
    repeat (8) begin
      logic fb = v[0] ^ s[0];
      v = {1'b0, v[15:1]};
      if (fb) v = v ^ 16'hA001;
      s = s >> 1;
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_in(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_byte = b;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic get_byte(input logic [7:0] exp, input int lat, input string tag);
    @(negedge clk); out_req = 1'b1;
    @(negedge clk); out_req = 1'b0;
    if (lat == 2) begin
      chk(!out_valid, {tag, " R9 early valid"}, 16'(out_valid), 16'd0);
      @(negedge clk);
    end
    chk(out_valid && out_byte == exp, tag, {7'd0, out_valid, out_byte}, {8'h01, exp});
  endtask

  task automatic pulse_bus_rst();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
    chk(!out_valid, "R8 valid after abort", 16'(out_valid), 16'd0);
  endtask

  // Full transaction from start address {hi,lo} through n_ff fill bytes.
  task automatic run_read(input logic [7:0] lo, input logic [7:0] hi, input int n_ff);
    int a = int'(lo[6:0]);
    int start = a % 32;
    logic [15:0] c;
    send_in(8'hA5); send_in(lo); send_in(hi);
    for (int p = a / 32; p < 4; p++) begin
      c = 16'h0000;
      if (p == a / 32) begin
        c = tb_crc(c, 8'hA5); c = tb_crc(c, lo); c = tb_crc(c, hi);
      end
      c = tb_crc(c, redir_of(p));
      get_byte(redir_of(p), 1, (p == a / 32) ? "R2 redirection" : "R6 redirection");
      get_byte(~c[7:0], 1, (p == a / 32) ? "R3 header crc lo" : "R6 redir crc lo");
      get_byte(~c[15:8], 1, (p == a / 32) ? "R3 header crc hi" : "R6 redir crc hi");
      c = 16'h0000;
      for (int o = start; o < 32; o++) begin
        logic [7:0] d = memval(p * 32 + o);
        c = tb_crc(c, d);
        get_byte(d, 2, "R4 data");
      end
      get_byte(~c[7:0], 1, "R5 page crc lo");
      get_byte(~c[15:8], 1, "R5 page crc hi");
      start = 0;
    end
    for (int k = 0; k < n_ff; k++) get_byte(8'hFF, 1, "R7 fill");
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!out_valid && !mem_rd_en, "R8 reset state", {14'd0, out_valid, mem_rd_en}, 16'd0);
  endtask

  task automatic t_high_bits_ignored();
    run_read(8'hCE, 8'h12, 2);   // addr 0x12CE -> 0x4E: page 2, offset 14
    pulse_bus_rst();
  endtask

  task automatic t_full_from_zero();
    run_read(8'h00, 8'h00, 3);
    pulse_bus_rst();
  endtask

  task automatic t_bad_command();
    bit seen = 1'b0;
    send_in(8'h33); send_in(8'h00); send_in(8'h00);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); out_req = 1'b1;
      @(negedge clk); out_req = 1'b0;
      repeat (3) begin
        if (out_valid || mem_rd_en) seen = 1'b1;
        @(negedge clk);
      end
    end
    chk(!seen, "R1 silent after bad command", 16'(seen), 16'd0);
    pulse_bus_rst();
    run_read(8'h7F, 8'h00, 2);   // last byte of last page
    pulse_bus_rst();
  endtask

  task automatic t_abort_mid();
    logic [15:0] c = 16'h0000;
    bit seen = 1'b0;
    send_in(8'hA5); send_in(8'h20); send_in(8'h00);
    c = tb_crc(c, 8'hA5); c = tb_crc(c, 8'h20); c = tb_crc(c, 8'h00); c = tb_crc(c, redir_of(1));
    get_byte(redir_of(1), 1, "R2 redirection page1");
    get_byte(~c[7:0], 1, "R3 header crc lo");
    get_byte(~c[15:8], 1, "R3 header crc hi");
    for (int o = 0; o < 3; o++) get_byte(memval(32 + o), 2, "R4 data");
    pulse_bus_rst();
    @(negedge clk); out_req = 1'b1;
    @(negedge clk); out_req = 1'b0;
    repeat (3) begin
      if (out_valid) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, "R8 request after abort ignored", 16'(seen), 16'd0);
    run_read(8'h1E, 8'h80, 1);
    pulse_bus_rst();
  endtask

  task automatic t_ignore_extra();
    logic [15:0] c = 16'h0000;
    send_in(8'hA5); send_in(8'h60); send_in(8'h00);
    c = tb_crc(c, 8'hA5); c = tb_crc(c, 8'h60); c = tb_crc(c, 8'h00); c = tb_crc(c, redir_of(3));
    get_byte(redir_of(3), 1, "R2 redirection page3");
    get_byte(~c[7:0], 1, "R3 header crc lo");
    get_byte(~c[15:8], 1, "R3 header crc hi");
    @(negedge clk); out_req = 1'b1;
    @(negedge clk);                       // byte pending: keep request, add stray input
    in_valid = 1'b1; in_byte = 8'h00;
    chk(!out_valid, "R10 pending not yet valid", 16'(out_valid), 16'd0);
    @(negedge clk); out_req = 1'b0; in_valid = 1'b0;
    chk(out_valid && out_byte == memval(96), "R10 data despite extra request",
        {7'd0, out_valid, out_byte}, {8'h01, memval(96)});
    @(negedge clk);
    chk(!out_valid, "R10 no second byte from extra request", 16'(out_valid), 16'd0);
    get_byte(memval(97), 2, "R10 next data in order");
    get_byte(memval(98), 2, "R10 next data in order");
    pulse_bus_rst();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_high_bits_ignored();
    t_full_from_zero();
    t_bad_command();
    t_abort_mid();
    t_ignore_extra();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule